// File: doc/BRIEF.md
# Accumulator Processor Core with Four-Pulse Register Transfers

This core is a small 8-bit processor built around one accumulator. It reads opcodes and operand words from a synchronous memory port and executes loads in three addressing modes, a store, add and subtract, single-bit shifts, an unconditional jump, a jump taken when the accumulator is zero, and a call/return pair. Only one return address can be held, so subroutines cannot nest. A halt instruction stops the core.

Every machine cycle is four clock cycles long, numbered pulse 0 to pulse 3. The registers behave like latching cells that can only set bits. A destination is therefore cleared in pulse 2 and loaded in pulse 3. Because a register cannot be read while it is being rewritten, values that depend on it are first staged in holding registers. These holding registers are cleared in pulse 0 and loaded in pulse 1. There is one for the next program counter, which comes from a dedicated +1 incrementer, one for the accumulator result, and a shadow copy of the control state. The memory address is latched in pulse 0 and held for the rest of the machine cycle.

A test environment attaches a memory with one cycle of read latency. It can watch the accumulator, program counter, return register and instruction register on the debug outputs.

Top module: `acc_cpu`

## Requirements
- R1: While `rstN` is low, the accumulator, program counter, return register and instruction register read zero, and `halted` and `memWe` are low. After release, execution starts by fetching from address 0.
- R2: A machine cycle is four clocks, and pulses advance 0,1,2,3,0. An instruction without an operand takes 2 machine cycles, an instruction with an operand takes 3, and the indirect load takes 4. A halt at address 0 raises `halted` on the 8th rising edge after reset release.
- R3: Each register update fully replaces the old value; no old bits survive. The accumulator changes only on the edges that end pulse 2 (clear) and pulse 3 (load).
- R4: The opcode is the low 4 bits of the word, and the upper 4 bits are ignored. The codes are: 0 no-op, 1 immediate load, 2 direct load, 3 indirect load, 4 store, 5 add, 6 subtract, 7 shift left, 8 shift right, 9 jump, A jump-if-zero, B call, C return, D halt. Codes 1–6 and 9–B take the next word as their operand. Codes E and F act as no-ops.
- R5: The immediate load puts the operand word itself into the accumulator.
- R6: The direct load puts the memory word at the operand address into the accumulator.
- R7: The indirect load reads an address from the operand address, then loads the word stored at that second address.
- R8: Add and subtract combine the accumulator with the word at the operand address, modulo 256.
- R9: Shift left and shift right move the accumulator by one bit and fill the vacated bit with zero.
- R10: The store makes exactly one write, with `memWe` high only in pulse 3. The address is the operand, and the data is the accumulator.
- R11: The jump loads the operand into the program counter. The jump-if-zero does so only when the accumulator is zero; otherwise execution continues after the operand.
- R12: The call saves the address that follows its operand in the return register and jumps to the operand. The return reloads the program counter from the return register.
- R13: After a halt, `halted` stays high, the program counter stays at the address after the halt opcode, and no write occurs.
- R14: `memAddr` changes only when pulse 0 begins and holds steady through pulses 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 8 | Memory word address |
| memWdata | output | 8 | Store data (accumulator) |
| memRdata | input | 8 | Read data, one clock after the address |
| memWe | output | 1 | Write strobe |
| halted | output | 1 | High once a halt has executed |
| dbgAcc | output | 8 | Accumulator view |
| dbgPc | output | 8 | Program counter view |
| dbgSr | output | 8 | Return register view |
| dbgIr | output | 8 | Instruction register view |

## Verification
Program results appear at whole machine-cycle boundaries: 8 clocks for an instruction without an operand, 12 for one with an operand, and 16 for the indirect load. The bench therefore runs each program until `halted` and compares the elapsed clock count with that sum. It reads the accumulator, program counter and memory only after that point. All sampling happens on the falling edge, so the register loads at the end of pulse 3 have always settled. The per-pulse rules are checked cycle by cycle by properties: the write pulse, the accumulator update edges and address stability.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W   = 4;
  localparam int N_DEST = 5;
  localparam int D_ACC  = 0;
  localparam int D_IR   = 1;
  localparam int D_OPR  = 2;
  localparam int D_PC   = 3;
  localparam int D_SR   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'h0, OP_LDI = 4'h1, OP_LDD = 4'h2, OP_LDN = 4'h3,
    OP_ST  = 4'h4, OP_ADD = 4'h5, OP_SUB = 4'h6, OP_SHL = 4'h7,
    OP_SHR = 4'h8, OP_JMP = 4'h9, OP_JZ  = 4'hA, OP_CALL = 4'hB,
    OP_RET = 4'hC, OP_HLT = 4'hD
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd1, ST_OPER = 3'd2, ST_IND = 3'd3, ST_EXEC = 3'd4, ST_HALT = 3'd5
  } cpuState_e;

  typedef enum logic [1:0] {PCS_HOLD, PCS_OPER, PCS_RET} pcSrc_e;

  typedef enum logic [2:0] {
    ALU_OPER, ALU_MEM, ALU_ADD, ALU_SUB, ALU_SHL, ALU_SHR
  } aluOp_e;

  typedef struct packed {
    logic              holdClr;   // pulse 0
    logic              holdLd;    // pulse 1
    logic              destClr;   // pulse 2
    logic              destLd;    // pulse 3
    logic              pcInc;
    logic              addrOper;
    logic [N_DEST-1:0] destEn;
    pcSrc_e            pcSrc;
    aluOp_e            aluOp;
    logic              memWr;
  } ctrlStrb_t;

  function automatic logic hasOperand(input logic [OP_W-1:0] op);
    case (opcode_e'(op))
      OP_LDI, OP_LDD, OP_LDN, OP_ST, OP_ADD, OP_SUB,
      OP_JMP, OP_JZ, OP_CALL: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/acc_cpu_setreg.sv
module acc_cpu_setreg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  // Set-only storage: a load can only add ones, so a clear must come first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    q <= RST_VAL;
    else if (clr) q <= '0;
    else if (ld)  q <= q | din;
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] fetchOp,
  input  logic [OP_W-1:0] irOp,
  input  logic            accZero,
  output ctrlStrb_t       strb,
  output logic [1:0]      phase,
  output logic            halted
);
  logic [2:0] stateQ, shadowQ, nextBits;
  cpuState_e  decState, nextState;
  logic p0, p1, p2, p3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 2'd0;
    else       phase <= phase + 2'd1;
  end

  assign p0 = (phase == 2'd0);
  assign p1 = (phase == 2'd1);
  assign p2 = (phase == 2'd2);
  assign p3 = (phase == 2'd3);

  // Shadow copies the current state in pulses 0/1; the live state is
  // rewritten in pulses 2/3 while decoding runs from the shadow.
  acc_cpu_setreg #(.W(3), .RST_VAL(ST_FETCH)) u_shadow (
    .clk(clk), .rstN(rstN), .clr(p0), .ld(p1), .din(stateQ), .q(shadowQ));

  acc_cpu_setreg #(.W(3), .RST_VAL(ST_FETCH)) u_state (
    .clk(clk), .rstN(rstN), .clr(p2), .ld(p3), .din(nextBits), .q(stateQ));

  assign decState = cpuState_e'(phase[1] ? shadowQ : stateQ);
  assign halted   = (decState == ST_HALT);
  assign nextBits = nextState;

  always_comb begin
    case (decState)
      ST_FETCH: nextState = hasOperand(fetchOp) ? ST_OPER : ST_EXEC;
      ST_OPER:  nextState = (irOp == OP_LDN) ? ST_IND : ST_EXEC;
      ST_IND:   nextState = ST_EXEC;
      ST_EXEC:  nextState = (irOp == OP_HLT) ? ST_HALT : ST_FETCH;
      ST_HALT:  nextState = ST_HALT;
      default:  nextState = ST_FETCH;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.holdClr = p0;
    strb.holdLd  = p1;
    strb.destClr = p2;
    strb.destLd  = p3;
    strb.pcSrc   = PCS_HOLD;
    strb.aluOp   = ALU_OPER;
    case (decState)
      ST_FETCH: begin
        strb.pcInc        = 1'b1;
        strb.destEn[D_IR] = 1'b1;
        strb.destEn[D_PC] = 1'b1;
      end
      ST_OPER: begin
        strb.pcInc         = 1'b1;
        strb.destEn[D_OPR] = 1'b1;
        strb.destEn[D_PC]  = 1'b1;
      end
      ST_IND: begin
        strb.addrOper      = 1'b1;
        strb.destEn[D_OPR] = 1'b1;
      end
      ST_EXEC: begin
        strb.addrOper = 1'b1;
        case (opcode_e'(irOp))
          OP_LDI: begin strb.aluOp = ALU_OPER; strb.destEn[D_ACC] = 1'b1; end
          OP_LDD,
          OP_LDN: begin strb.aluOp = ALU_MEM;  strb.destEn[D_ACC] = 1'b1; end
          OP_ADD: begin strb.aluOp = ALU_ADD;  strb.destEn[D_ACC] = 1'b1; end
          OP_SUB: begin strb.aluOp = ALU_SUB;  strb.destEn[D_ACC] = 1'b1; end
          OP_SHL: begin strb.aluOp = ALU_SHL;  strb.destEn[D_ACC] = 1'b1; end
          OP_SHR: begin strb.aluOp = ALU_SHR;  strb.destEn[D_ACC] = 1'b1; end
          OP_ST:  strb.memWr = p3;
          OP_JMP: begin strb.pcSrc = PCS_OPER; strb.destEn[D_PC] = 1'b1; end
          OP_JZ:  begin strb.pcSrc = PCS_OPER; strb.destEn[D_PC] = accZero; end
          OP_CALL: begin
            strb.pcSrc        = PCS_OPER;
            strb.destEn[D_PC] = 1'b1;
            strb.destEn[D_SR] = 1'b1;
          end
          OP_RET: begin strb.pcSrc = PCS_RET; strb.destEn[D_PC] = 1'b1; end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              accZero,
  output logic [OP_W-1:0]   irOp,
  output logic [DATA_W-1:0] dbgAcc,
  output logic [DATA_W-1:0] dbgPc,
  output logic [DATA_W-1:0] dbgSr,
  output logic [DATA_W-1:0] dbgIr
);
  logic [DATA_W-1:0] destIn [N_DEST];
  logic [DATA_W-1:0] destQ  [N_DEST];
  logic [DATA_W-1:0] accQ, irQ, oprQ, pcQ, srQ;
  logic [DATA_W-1:0] pcHoldQ, aluHoldQ, pcHoldIn, aluRes, pcNext;
  logic [DATA_W-1:0] addrPick, addrLatch;

  generate
    for (genvar g = 0; g < N_DEST; g++) begin : g_dest
      acc_cpu_setreg #(.W(DATA_W)) u_reg (
        .clk(clk), .rstN(rstN),
        .clr(strb.destClr & strb.destEn[g]),
        .ld (strb.destLd  & strb.destEn[g]),
        .din(destIn[g]), .q(destQ[g]));
    end
  endgenerate

  assign accQ = destQ[D_ACC];
  assign irQ  = destQ[D_IR];
  assign oprQ = destQ[D_OPR];
  assign pcQ  = destQ[D_PC];
  assign srQ  = destQ[D_SR];

  // Dedicated incrementer feeding the PC holding register.
  assign pcHoldIn = strb.pcInc ? pcQ + DATA_W'(1) : pcQ;

  acc_cpu_setreg #(.W(DATA_W)) u_pcHold (
    .clk(clk), .rstN(rstN), .clr(strb.holdClr), .ld(strb.holdLd),
    .din(pcHoldIn), .q(pcHoldQ));

  always_comb begin
    case (strb.aluOp)
      ALU_OPER: aluRes = oprQ;
      ALU_MEM:  aluRes = memRdata;
      ALU_ADD:  aluRes = accQ + memRdata;
      ALU_SUB:  aluRes = accQ - memRdata;
      ALU_SHL:  aluRes = {accQ[DATA_W-2:0], 1'b0};
      ALU_SHR:  aluRes = {1'b0, accQ[DATA_W-1:1]};
      default:  aluRes = accQ;
    endcase
  end

  acc_cpu_setreg #(.W(DATA_W)) u_aluHold (
    .clk(clk), .rstN(rstN), .clr(strb.holdClr), .ld(strb.holdLd),
    .din(aluRes), .q(aluHoldQ));

  always_comb begin
    case (strb.pcSrc)
      PCS_OPER: pcNext = oprQ;
      PCS_RET:  pcNext = srQ;
      default:  pcNext = pcHoldQ;
    endcase
  end

  always_comb begin
    destIn[D_ACC] = aluHoldQ;
    destIn[D_IR]  = memRdata;
    destIn[D_OPR] = memRdata;
    destIn[D_PC]  = pcNext;
    destIn[D_SR]  = pcHoldQ;
  end

  assign addrPick = strb.addrOper ? oprQ : pcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrLatch <= '0;
    else if (strb.holdClr) addrLatch <= addrPick;
  end

  assign memAddr  = strb.holdClr ? addrPick : addrLatch;
  assign memWdata = accQ;
  assign accZero  = (accQ == '0);
  assign irOp     = irQ[OP_W-1:0];
  assign dbgAcc   = accQ;
  assign dbgPc    = pcQ;
  assign dbgSr    = srQ;
  assign dbgIr    = irQ;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  output logic              halted,
  output logic [DATA_W-1:0] dbgAcc,
  output logic [DATA_W-1:0] dbgPc,
  output logic [DATA_W-1:0] dbgSr,
  output logic [DATA_W-1:0] dbgIr
);
  ctrlStrb_t       strb;
  logic [1:0]      phaseNow;
  logic            accZero;
  logic [OP_W-1:0] irOp;

  acc_cpu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchOp(memRdata[OP_W-1:0]), .irOp(irOp),
    .accZero(accZero), .strb(strb), .phase(phaseNow), .halted(halted));

  acc_cpu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .accZero(accZero), .irOp(irOp),
    .dbgAcc(dbgAcc), .dbgPc(dbgPc), .dbgSr(dbgSr), .dbgIr(dbgIr));

  assign memWe = strb.memWr;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        phaseNow,
  input logic [DATA_W-1:0] memAddr,
  input logic              memWe,
  input logic              halted,
  input logic [DATA_W-1:0] dbgPc,
  input logic [DATA_W-1:0] dbgAcc
);
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    phaseNow == 2'd3 |=> phaseNow == 2'd0);

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    phaseNow != 2'd3 |=> phaseNow == 2'($past(phaseNow) + 2'd1));

  p_acc_edges_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phaseNow == 2'd1 || phaseNow == 2'd2) |-> $stable(dbgAcc));

  p_we_pulse3_r10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> phaseNow == 2'd3);

  p_halt_sticky_r13: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  p_halt_frozen_r13: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> ($stable(dbgPc) && !memWe));

  p_addr_steady_r14: assert property (@(posedge clk) disable iff (!rstN)
    phaseNow != 2'd0 |-> $stable(memAddr));
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .phaseNow(phaseNow), .memAddr(memAddr),
  .memWe(memWe), .halted(halted), .dbgPc(dbgPc), .dbgAcc(dbgAcc));

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] memAddr, memWdata, memRdata;
  logic       memWe, halted;
  logic [7:0] dbgAcc, dbgPc, dbgSr, dbgIr;
  logic       tbLoad = 1'b0;
  logic [7:0] tbAddr = '0, tbData = '0;
  logic [7:0] mem [256];
  int         weCount = 0;
  int         total = 0, fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  acc_cpu u_dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe), .halted(halted),
    .dbgAcc(dbgAcc), .dbgPc(dbgPc), .dbgSr(dbgSr), .dbgIr(dbgIr));

  always @(posedge clk) begin
    if (tbLoad) mem[tbAddr] <= tbData;
    else if (memWe) begin
      mem[memAddr] <= memWdata;
      weCount <= weCount + 1;
    end
    memRdata <= mem[memAddr];
  end

  // {op, arg, init, dataAt80, dataAt90, expAcc, expCycles}
  localparam logic [55:0] VEC [12] = '{
    {8'h01, 8'h5A, 8'h0F, 8'h00, 8'h00, 8'h5A, 8'd32},  // R5 R3
    {8'h02, 8'h80, 8'hC3, 8'h3C, 8'h00, 8'h3C, 8'd32},  // R6 R3
    {8'h03, 8'h80, 8'h00, 8'h90, 8'hA5, 8'hA5, 8'd36},  // R7
    {8'h05, 8'h80, 8'h70, 8'h25, 8'h00, 8'h95, 8'd32},  // R8
    {8'h05, 8'h80, 8'hF0, 8'h20, 8'h00, 8'h10, 8'd32},  // R8 wrap
    {8'h06, 8'h80, 8'h10, 8'h01, 8'h00, 8'h0F, 8'd32},  // R8
    {8'h06, 8'h80, 8'h00, 8'h01, 8'h00, 8'hFF, 8'd32},  // R8 borrow
    {8'h07, 8'h00, 8'h81, 8'h00, 8'h00, 8'h02, 8'd28},  // R9
    {8'h08, 8'h00, 8'h81, 8'h00, 8'h00, 8'h40, 8'd28},  // R9
    {8'h00, 8'h00, 8'h33, 8'h00, 8'h00, 8'h33, 8'd28},  // R4 no-op
    {8'h0F, 8'h00, 8'h33, 8'h00, 8'h00, 8'h33, 8'd28},  // R4 unassigned
    {8'h75, 8'h80, 8'h01, 8'h02, 8'h00, 8'h03, 8'd32}   // R4 upper bits
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit tbHasOp(input logic [7:0] op);
    case (op[3:0])
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h9, 4'hA, 4'hB: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tbLoad = 1'b1; tbAddr = a; tbData = d;
    @(posedge clk);
  endtask

  task automatic startProg();
    @(negedge clk);
    rstN = 1'b0;
    for (int a = 0; a < 256; a++) poke(8'(a), 8'h00);
  endtask

  task automatic runToHalt(output int cyc);
    @(negedge clk);
    tbLoad = 1'b0;
    rstN = 1'b1;
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end while (!halted && cyc < 400);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    int cyc;
    int weBefore;
    logic [7:0] pcSave;

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 acc", dbgAcc, 0);
    chk("R1 pc", dbgPc, 0);
    chk("R1 sr", dbgSr, 0);
    chk("R1 ir", dbgIr, 0);
    chk("R1 halted", halted, 0);
    chk("R1 memWe", memWe, 0);

    // Vector table: LDI init ; op [arg] ; HLT
    for (int i = 0; i < 12; i++) begin
      logic [55:0] v;
      logic [7:0] op;
      v = VEC[i];
      op = v[55:48];
      startProg();
      poke(8'h00, 8'h01);
      poke(8'h01, v[39:32]);
      poke(8'h02, op);
      if (tbHasOp(op)) begin
        poke(8'h03, v[47:40]);
        poke(8'h04, 8'h0D);
      end else begin
        poke(8'h03, 8'h0D);
      end
      poke(8'h80, v[31:24]);
      poke(8'h90, v[23:16]);
      runToHalt(cyc);
      chk($sformatf("R5-vector %0d acc (R3 R4 R6 R7 R8 R9)", i), dbgAcc, v[15:8]);
      chk($sformatf("R2 vector %0d cycles", i), cyc, v[7:0]);
      chk($sformatf("R13 vector %0d pc", i), dbgPc, tbHasOp(op) ? 5 : 4);
    end

    // R2 halt at address 0
    startProg();
    poke(8'h00, 8'h0D);
    runToHalt(cyc);
    chk("R2 halt cycles", cyc, 8);
    chk("R13 pc after halt", dbgPc, 1);

    // R10 store
    startProg();
    poke(8'h00, 8'h01); poke(8'h01, 8'h77);
    poke(8'h02, 8'h04); poke(8'h03, 8'h85);
    poke(8'h04, 8'h0D);
    weBefore = weCount;
    runToHalt(cyc);
    chk("R10 stored word", mem[8'h85], 8'h77);
    chk("R10 neighbour below", mem[8'h84], 8'h00);
    chk("R10 neighbour above", mem[8'h86], 8'h00);
    chk("R10 write count", weCount - weBefore, 1);
    chk("R10 cycles", cyc, 32);

    // R13 freeze after halt
    pcSave = dbgPc;
    weBefore = weCount;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R13 pc frozen", dbgPc, pcSave);
    chk("R13 still halted", halted, 1);
    chk("R13 no writes", weCount - weBefore, 0);

    // R11 jump
    startProg();
    poke(8'h00, 8'h09); poke(8'h01, 8'h10);
    poke(8'h02, 8'h01); poke(8'h03, 8'h11); poke(8'h04, 8'h0D);
    poke(8'h10, 8'h01); poke(8'h11, 8'h22); poke(8'h12, 8'h0D);
    runToHalt(cyc);
    chk("R11 jmp acc", dbgAcc, 8'h22);
    chk("R11 jmp pc", dbgPc, 8'h13);

    // R11 jump-if-zero taken / not taken
    for (int t = 0; t < 2; t++) begin
      startProg();
      poke(8'h00, 8'h01); poke(8'h01, (t == 0) ? 8'h00 : 8'h05);
      poke(8'h02, 8'h0A); poke(8'h03, 8'h10);
      poke(8'h04, 8'h01); poke(8'h05, 8'h11); poke(8'h06, 8'h0D);
      poke(8'h10, 8'h01); poke(8'h11, 8'h22); poke(8'h12, 8'h0D);
      runToHalt(cyc);
      chk($sformatf("R11 jz case %0d acc", t), dbgAcc, (t == 0) ? 8'h22 : 8'h11);
      chk($sformatf("R11 jz case %0d pc", t), dbgPc, (t == 0) ? 8'h13 : 8'h07);
    end

    // R12 call / return
    startProg();
    poke(8'h00, 8'h0B); poke(8'h01, 8'h20);
    poke(8'h02, 8'h0D);
    poke(8'h20, 8'h01); poke(8'h21, 8'h44); poke(8'h22, 8'h0C);
    runToHalt(cyc);
    chk("R12 acc", dbgAcc, 8'h44);
    chk("R12 sr", dbgSr, 8'h02);
    chk("R12 pc", dbgPc, 8'h03);
    chk("R12 cycles", cyc, 40);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule